// File: doc/BRIEF.md
# Automatic Temperature-to-PWM Fan Controller

This block turns an 8-bit unsigned temperature reading into a pulse-width modulated fan drive. The reading is first corrected by a 5-bit signed offset. The corrected value then drives two things. One is a hysteretic over-temperature flag. The other is the fan duty cycle. In automatic mode, the duty is a linear ramp that starts at a programmed minimum temperature. In manual mode, the duty is taken straight from a register.

Whenever the commanded duty leaves zero, the fan is driven at full duty for a selectable spin-up interval before it follows the command. While the over-temperature flag is set, the fan is also held at full duty. The PWM step rate is divided from a clock enable by a selectable power of two. All configuration inputs are treated as register outputs held by the surrounding logic.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, `pwm_o`, `therm_o` and `spin_o` are all 0.
- R2: The corrected temperature is `temp_i` plus the sign-extended 5-bit two's-complement `ofs_i` (range -16..+15). The sum saturates to 0 and to 255 instead of wrapping.
- R3: In automatic mode (`auto_i`=1), the commanded duty is 0 when the corrected temperature is below `tmin_i`. Otherwise it is min(15, ((corr - tmin_i) * 16) >> (`rsel_i` + 2)), so full duty is reached `4 << rsel_i` degrees above the minimum.
- R4: In manual mode (`auto_i`=0), the commanded duty equals `man_duty_i` (0..15).
- R5: One PWM period is 15 steps. `pwm_o` is high for `duty` of those steps, so a duty of 15 is constantly high and a duty of 0 is constantly low. One step lasts 2^`fsel_i` enabled clocks. With `ce` held high, the period is therefore 15 * 2^`fsel_i` clocks.
- R6: When the commanded duty changes from 0 to nonzero, `spin_o` goes high for (`spin_sel_i` + 1) * SPIN_UNIT enabled clocks. `spin_o` is cleared at once if the commanded duty returns to 0.
- R7: While `spin_o` or `therm_o` is high, the PWM duty is forced to 15, whatever the commanded duty is.
- R8: `therm_o` sets when the corrected temperature is at or above `tlim_i`. It clears when the corrected temperature plus 4 is below `tlim_i`, and holds its value otherwise. It is a register, updated on the clock edge after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable for the PWM step and spin-up timing |
| temp_i | input | 8 | Raw temperature reading, unsigned degrees |
| ofs_i | input | 5 | Signed temperature correction |
| auto_i | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| tmin_i | input | 8 | Temperature at which the automatic ramp starts |
| rsel_i | input | 2 | Ramp width select, width = 4 << rsel_i degrees |
| man_duty_i | input | 4 | Manual duty, in fifteenths |
| spin_sel_i | input | 2 | Spin-up length select |
| fsel_i | input | 2 | PWM step divider select |
| tlim_i | input | 8 | Over-temperature limit |
| pwm_o | output | 1 | Fan drive |
| therm_o | output | 1 | Over-temperature flag |
| spin_o | output | 1 | High during the spin-up interval |

## Verification
The properties assume that configuration and temperature inputs change only between measurements. They also assume that `tlim_i` and `tmin_i` describe a setting that is held for at least one clock, so that a one-cycle consequence of the corrected temperature is meaningful.

The bench respects these assumptions. It changes inputs only on falling clock edges. It then waits for any spin-up interval to end before it measures duty over whole PWM periods, with the configuration held constant. It sweeps every temperature value under several offset, minimum and ramp settings, with `ce` held high throughout.

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl #(
  parameter int TW        = 8,
  parameter int DW        = 4,
  parameter int OW        = 5,
  parameter int RSW       = 2,
  parameter int SSW       = 2,
  parameter int FSW       = 2,
  parameter int SPIN_UNIT = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [TW-1:0]  temp_i,
  input  logic [OW-1:0]  ofs_i,
  input  logic           auto_i,
  input  logic [TW-1:0]  tmin_i,
  input  logic [RSW-1:0] rsel_i,
  input  logic [DW-1:0]  man_duty_i,
  input  logic [SSW-1:0] spin_sel_i,
  input  logic [FSW-1:0] fsel_i,
  input  logic [TW-1:0]  tlim_i,
  output logic           pwm_o,
  output logic           therm_o,
  output logic           spin_o
);
  localparam int DMAX = (1 << DW) - 1;
  localparam int SCW  = TW + DW;
  localparam int SPW  = $clog2(SPIN_UNIT * (1 << SSW) + 1);
  localparam int PSW  = ((1 << FSW) - 1) > 0 ? ((1 << FSW) - 1) : 1;
  localparam int HYST = 4;

  logic [TW+1:0]  sum;
  logic [TW-1:0]  corr, delta;
  logic [SCW-1:0] scaled;
  logic [DW-1:0]  auto_duty, cmd, eff, cnt;
  logic [SPW-1:0] spin_cnt, spin_len;
  logic [PSW-1:0] pre, pre_top;
  logic           on_q, step;

  assign sum   = {2'b00, temp_i} + {{(TW+2-OW){ofs_i[OW-1]}}, ofs_i};
  assign corr  = sum[TW+1] ? '0 : (sum[TW] ? '1 : sum[TW-1:0]);
  assign delta = corr - tmin_i;
  assign scaled = {delta, {DW{1'b0}}} >> (32'(rsel_i) + 2);
  assign auto_duty = (corr < tmin_i) ? '0 :
                     (scaled > SCW'(DMAX) ? DW'(DMAX) : scaled[DW-1:0]);
  assign cmd = auto_i ? auto_duty : man_duty_i;

  assign spin_len = SPW'((32'(spin_sel_i) + 1) * SPIN_UNIT);
  assign spin_o   = (spin_cnt != '0);
  assign eff      = (therm_o || spin_o) ? DW'(DMAX) : cmd;

  assign pre_top = PSW'((32'd1 << fsel_i) - 1);
  assign step    = ce && (pre >= pre_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      therm_o <= 1'b0;
    end else if (corr >= tlim_i) begin
      therm_o <= 1'b1;
    end else if ({1'b0, corr} + (TW+1)'(HYST) < {1'b0, tlim_i}) begin
      therm_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      spin_cnt <= '0;
    end else begin
      on_q <= (cmd != '0);
      if (cmd == '0)
        spin_cnt <= '0;
      else if (!on_q)
        spin_cnt <= spin_len;
      else if (ce && spin_cnt != '0)
        spin_cnt <= spin_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt   <= '0;
      pwm_o <= 1'b0;
    end else begin
      if (ce) pre <= step ? '0 : pre + 1'b1;
      if (step) cnt <= (cnt == DW'(DMAX - 1)) ? '0 : cnt + 1'b1;
      pwm_o <= (cnt < eff);
    end
  end
endmodule

module fan_pwm_ctrl_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_i,
  input logic [TW-1:0] corr,
  input logic [TW-1:0] tmin_i,
  input logic [TW-1:0] tlim_i,
  input logic          pwm_o,
  input logic          therm_o,
  input logic          spin_o
);
  AST_THERM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (corr >= tlim_i) |=> therm_o); // R8
  AST_THERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_o && ({1'b0, corr} + 4 >= {1'b0, tlim_i})) |=> therm_o); // R8
  AST_SPIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    spin_o |=> pwm_o); // R7
  AST_THERM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    therm_o |=> pwm_o); // R7
  AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && corr < tmin_i && !therm_o && !spin_o) |=> !pwm_o); // R3
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_i(auto_i), .corr(corr),
  .tmin_i(tmin_i), .tlim_i(tlim_i), .pwm_o(pwm_o),
  .therm_o(therm_o), .spin_o(spin_o)
);

// File: tb/fan_pwm_ctrl_tb.sv
module fan_pwm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SPIN_UNIT  = 64;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b1, auto_i = 1'b0;
  logic [7:0] temp_i = 0, tmin_i = 0, tlim_i = 8'd255;
  logic [4:0] ofs_i = 0;
  logic [1:0] rsel_i = 0, spin_sel_i = 0, fsel_i = 0;
  logic [3:0] man_duty_i = 0;
  logic pwm_o, therm_o, spin_o;

  int checks = 0, errors = 0;
  bit mth = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_pwm_ctrl #(.SPIN_UNIT(SPIN_UNIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .temp_i(temp_i), .ofs_i(ofs_i),
    .auto_i(auto_i), .tmin_i(tmin_i), .rsel_i(rsel_i), .man_duty_i(man_duty_i),
    .spin_sel_i(spin_sel_i), .fsel_i(fsel_i), .tlim_i(tlim_i),
    .pwm_o(pwm_o), .therm_o(therm_o), .spin_o(spin_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int corr_of(input int t, input int o);
    int c = t + o;
    if (c < 0) c = 0;
    if (c > 255) c = 255;
    return c;
  endfunction

  function automatic int auto_exp(input int c, input int mn, input int rs);
    int s;
    if (c < mn) return 0;
    s = ((c - mn) * 16) >> (rs + 2);
    return (s > 15) ? 15 : s;
  endfunction

  task automatic settle();
    int guard = 0;
    repeat (2) @(negedge clk);
    while (spin_o && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic count_high(input int f, output int n);
    n = 0;
    for (int i = 0; i < (15 << f); i++) begin
      n += pwm_o;
      @(negedge clk);
    end
  endtask

  task automatic auto_sweep(input int o, input int rs, input int mn);
    int n, c, e;
    auto_i = 1; fsel_i = 0; tlim_i = 8'd255;
    ofs_i = 5'(o); rsel_i = 2'(rs); tmin_i = 8'(mn);
    for (int t = 0; t < 256; t++) begin
      temp_i = 8'(t);
      c = corr_of(t, o);
      if (c >= 255) mth = 1; else if (c + 4 < 255) mth = 0;
      e = mth ? 15 : auto_exp(c, mn, rs);
      settle();
      count_high(0, n);
      chk($sformatf("R2/R3 auto ofs=%0d rsel=%0d tmin=%0d temp=%0d", o, rs, mn, t), n, e);
    end
  endtask

  task automatic therm_step(input int t, input int exp);
    temp_i = 8'(t);
    repeat (2) @(negedge clk);
    chk($sformatf("R8 therm temp=%0d lim=%0d", t, tlim_i), therm_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, prev, len, guard;
    repeat (3) @(negedge clk);
    chk("R1 pwm after reset", pwm_o, 0);
    chk("R1 therm after reset", therm_o, 0);
    chk("R1 spin after reset", spin_o, 0);
    rst_n = 1;
    @(negedge clk);

    auto_sweep(0, 0, 40);
    auto_sweep(0, 1, 40);
    auto_sweep(0, 2, 100);
    auto_sweep(0, 3, 100);
    auto_sweep(15, 2, 60);
    auto_sweep(-16, 2, 60);
    auto_sweep(-1, 3, 0);
    auto_sweep(7, 1, 200);

    auto_i = 0; ofs_i = 0; temp_i = 0; fsel_i = 1;
    for (int d = 0; d < 16; d++) begin
      man_duty_i = 4'(d);
      settle();
      count_high(1, n);
      chk($sformatf("R4 manual duty=%0d", d), n, d << 1);
    end

    man_duty_i = 7;
    for (int f = 0; f < 4; f++) begin
      fsel_i = 2'(f);
      settle();
      repeat (15 << f) @(negedge clk);
      count_high(f, n);
      chk($sformatf("R5 high count fsel=%0d", f), n, 7 << f);
      prev = pwm_o; guard = 0;
      while (!(pwm_o && !prev) && guard < 400) begin prev = pwm_o; @(negedge clk); guard++; end
      len = 0; prev = pwm_o;
      @(negedge clk); len++;
      while (!(pwm_o && !prev) && len < 400) begin prev = pwm_o; @(negedge clk); len++; end
      chk($sformatf("R5 period fsel=%0d", f), len, 15 << f);
    end

    fsel_i = 0;
    for (int s = 0; s < 4; s++) begin
      spin_sel_i = 2'(s);
      man_duty_i = 0;
      repeat (4) @(negedge clk);
      man_duty_i = 3;
      @(negedge clk);
      len = 0; n = 0;
      while (spin_o && len < 1000) begin
        if (len > 0 && !pwm_o) n++;
        len++;
        @(negedge clk);
      end
      chk($sformatf("R6 spin length sel=%0d", s), len, (s + 1) * SPIN_UNIT);
      chk($sformatf("R7 pwm low during spin sel=%0d", s), n, 0);
    end
    man_duty_i = 0;
    @(negedge clk);
    man_duty_i = 3;
    repeat (5) @(negedge clk);
    man_duty_i = 0;
    repeat (2) @(negedge clk);
    chk("R6 spin cleared when command returns to zero", spin_o, 0);

    man_duty_i = 0; tlim_i = 100;
    therm_step(99, 0);
    therm_step(100, 1);
    count_high(0, n);
    chk("R7 therm forces full duty", n, 15);
    therm_step(97, 1);
    therm_step(96, 1);
    therm_step(95, 0);
    therm_step(99, 0);
    therm_step(120, 1);
    ofs_i = 5'(-16);
    therm_step(115, 1);
    therm_step(111, 0);
    ofs_i = 5'(15);
    therm_step(85, 1);
    ofs_i = 0;
    tlim_i = 2;
    therm_step(2, 1);
    therm_step(0, 1);
    tlim_i = 255;
    ofs_i = 5'(15);
    therm_step(250, 1);
    ofs_i = 0;
    therm_step(250, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule